// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This block sits on the host side of a bridge and turns two-step processor I/O port sequences into configuration transactions. Software first writes a 32-bit selector to the address port. The selector names a target bus, device, function and dword register. Later accesses to the four-byte data port window then become configuration reads or writes on a simple request/response channel toward the bus logic.

For each data-port access the block compares the selected bus with a programmable primary bus number. If they are equal it forms a local cycle: a one-hot device select plus function and register bits, with the low address bits at 00. Otherwise it forms a forwarding cycle that carries bus, device, function and register, with the low bits at 01. Byte, word and dword accesses are supported. Byte enables follow little-endian lane order, so the lowest port address maps to the least significant byte. Any access the block does not claim is handed back as ordinary I/O through a pass flag.

The processor side issues one single-cycle request and waits for the acknowledge before issuing the next. Requests that arrive while a configuration transaction is outstanding are dropped.

Top module: `cfg_addr_xlat`

## Requirements
- R1: After reset, io_ack, io_pass and cfg_req are low, and a dword read of the address port returns 0 (enable clear).
- R2: A dword write to port 0x0CF8 stores the selector and raises io_ack one cycle after the request. A later dword read of 0x0CF8 returns the stored value with bits 30:24 and 1:0 forced to zero. The fields are: bit 31 enable, 23:16 bus, 15:11 device, 10:8 function, 7:2 register index.
- R3: An access that is not claimed raises io_ack and io_pass together one cycle after the request, and produces no cfg_req. Unclaimed accesses include a non-dword access to 0x0CF8..0x0CFB and any port outside 0x0CF8..0x0CFF. An unclaimed access leaves the stored selector unchanged.
- R4: While the enable bit is clear, data-port accesses (0x0CFC..0x0CFF) are passed through as in R3 and issue no cfg_req.
- R5: When the selected bus equals primary_bus, cfg_type1 is 0. cfg_addr then holds the function in bits 10:8 and the register index in bits 7:2, with all other bits zero. cfg_idsel has only the bit numbered by the device set.
- R6: When the selected bus differs from primary_bus, cfg_type1 is 1 and cfg_idsel is zero. cfg_addr = {8'h00, bus, device, function, register, 2'b01}.
- R7: Byte enables follow the lane given by the port's low two bits. A byte at 0x0CFC+k sets bit k. A word at 0x0CFC gives 0011 and a word at 0x0CFE gives 1100. A dword at 0x0CFC gives 1111. A word at an odd port, a dword not at 0x0CFC, or io_size 3 is passed through as in R3. io_size encoding: 0 byte, 1 word, 2 dword.
- R8: A claimed data-port access raises cfg_req for exactly one cycle, one cycle after the request. cfg_we equals io_we and cfg_wdata equals io_wdata unchanged.
- R9: io_ack rises one cycle after cfg_rsp_valid. For a read, io_rdata carries cfg_rsp_rdata, or all ones when cfg_rsp_err marks a missing target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Single-cycle processor I/O request |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port byte address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Write data, already placed in its lanes |
| io_ack | output | 1 | Access complete |
| io_pass | output | 1 | Access not claimed; route as ordinary I/O |
| io_rdata | output | 32 | Read data |
| primary_bus | input | 8 | Bus number directly behind the bridge |
| cfg_req | output | 1 | Configuration request pulse |
| cfg_we | output | 1 | Configuration write |
| cfg_type1 | output | 1 | 1 = forwarding cycle, 0 = local cycle |
| cfg_addr | output | 32 | Formed configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_idsel | output | 32 | One-hot device select for local cycles |
| cfg_rsp_valid | input | 1 | Response strobe from bus side |
| cfg_rsp_err | input | 1 | Target absent |
| cfg_rsp_rdata | input | 32 | Response read data |

## Verification
A corrupted stored selector is visible at once on the next dword read of the address port. It also shows up on the very next configuration request as a wrong cfg_addr, a wrong device select or a wrong local/forwarding choice. A stuck or wrong state in the wait handshake shows within a cycle or two, as a missing, early or duplicated io_ack or cfg_req. Wrong lane decoding appears on cfg_be or io_pass at the first access of the affected size and alignment.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  localparam int EN_BIT  = 31;
  localparam int BUS_LSB = 16;
  localparam int BUS_W   = 8;
  localparam int DEV_LSB = 11;
  localparam int DEV_W   = 5;
  localparam int FN_LSB  = 8;
  localparam int FN_W    = 3;
  localparam int REG_LSB = 2;
  localparam int REG_W   = 6;
  localparam int NDEV    = 1 << DEV_W;
  localparam int LOW_W   = FN_W + REG_W + 2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} io_size_e;
  typedef enum logic [1:0] {K_PASS, K_SEL_WR, K_SEL_RD, K_CFG} acc_kind_e;
  typedef enum logic {ST_IDLE, ST_WAIT} xlat_state_e;

  function automatic logic [31:0] sel_keep_mask();
    logic [31:0] m;
    m = '0;
    m[EN_BIT] = 1'b1;
    m[BUS_LSB +: BUS_W] = '1;
    m[DEV_LSB +: DEV_W] = '1;
    m[FN_LSB +: FN_W] = '1;
    m[REG_LSB +: REG_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_xlat_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic             io_we,
  input  logic             enable,
  output acc_kind_e        kind,
  output logic [3:0]       be
);
  logic [1:0] lane;
  logic       in_window;

  assign lane      = io_addr[1:0];
  assign in_window = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

  always_comb begin
    kind = K_PASS;
    be   = 4'b0000;
    if (io_addr == ADDR_PORT && io_size == SZ_DWORD) begin
      kind = io_we ? K_SEL_WR : K_SEL_RD;
    end else if (enable && in_window) begin
      case (io_size)
        SZ_BYTE:  be = 4'b0001 << lane;
        SZ_WORD:  if (!lane[0]) be = 4'b0011 << lane;
        SZ_DWORD: if (lane == 2'd0) be = 4'b1111;
        default:  be = 4'b0000;
      endcase
      if (be != 4'b0000) kind = K_CFG;
    end
  end
endmodule

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
  import cfg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] sel
);
  localparam logic [31:0] KEEP = sel_keep_mask();

  always_ff @(posedge clk) begin
    if (rst) sel <= '0;
    else if (wr) sel <= wdata & KEEP;
  end
endmodule

// File: rtl/cfg_cycle_former.sv
module cfg_cycle_former
  import cfg_xlat_pkg::*;
(
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [REG_W-1:0] regi,
  input  logic [BUS_W-1:0] primary_bus,
  output logic             type1,
  output logic [31:0]      addr,
  output logic [NDEV-1:0]  idsel
);
  assign type1 = (bus != primary_bus);

  always_comb begin
    if (type1)
      addr = {{(32-BUS_W-DEV_W-LOW_W){1'b0}}, bus, dev, fn, regi, 2'b01};
    else
      addr = {{(32-LOW_W){1'b0}}, fn, regi, 2'b00};
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_idsel
    assign idsel[g] = !type1 && (dev == DEV_W'(g));
  end
endmodule

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic             io_pass,
  output logic [31:0]      io_rdata,
  input  logic [7:0]       primary_bus,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic             cfg_type1,
  output logic [31:0]      cfg_addr,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_idsel,
  input  logic             cfg_rsp_valid,
  input  logic             cfg_rsp_err,
  input  logic [31:0]      cfg_rsp_rdata
);
  xlat_state_e     state;
  acc_kind_e       kind;
  logic [3:0]      be;
  logic [31:0]     sel;
  logic            sel_wr;
  logic            f_type1;
  logic [31:0]     f_addr;
  logic [NDEV-1:0] f_idsel;
  logic            take;

  assign take   = io_req && (state == ST_IDLE);
  assign sel_wr = take && (kind == K_SEL_WR);

  cfg_port_decode #(
    .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_decode (
    .io_addr(io_addr), .io_size(io_size), .io_we(io_we),
    .enable(sel[EN_BIT]), .kind(kind), .be(be)
  );

  cfg_sel_reg u_sel (
    .clk(clk), .rst(rst), .wr(sel_wr), .wdata(io_wdata), .sel(sel)
  );

  cfg_cycle_former u_former (
    .bus(sel[BUS_LSB +: BUS_W]), .dev(sel[DEV_LSB +: DEV_W]),
    .fn(sel[FN_LSB +: FN_W]), .regi(sel[REG_LSB +: REG_W]),
    .primary_bus(primary_bus), .type1(f_type1), .addr(f_addr), .idsel(f_idsel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_type1 <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      cfg_idsel <= '0;
    end else begin
      io_ack  <= 1'b0;
      io_pass <= 1'b0;
      cfg_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (io_req) begin
            case (kind)
              K_SEL_WR: io_ack <= 1'b1;
              K_SEL_RD: begin
                io_ack   <= 1'b1;
                io_rdata <= sel;
              end
              K_CFG: begin
                cfg_req   <= 1'b1;
                cfg_we    <= io_we;
                cfg_type1 <= f_type1;
                cfg_addr  <= f_addr;
                cfg_idsel <= 32'(f_idsel);
                cfg_be    <= be;
                cfg_wdata <= io_wdata;
                state     <= ST_WAIT;
              end
              default: begin
                io_ack   <= 1'b1;
                io_pass  <= 1'b1;
                io_rdata <= '0;
              end
            endcase
          end
        end
        default: begin
          if (cfg_rsp_valid) begin
            io_ack   <= 1'b1;
            io_rdata <= cfg_rsp_err ? '1 : cfg_rsp_rdata;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module cfg_addr_xlat_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_req,
  input logic        io_ack,
  input logic        io_pass,
  input logic        cfg_req,
  input logic        cfg_type1,
  input logic [31:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_idsel,
  input logic        cfg_rsp_valid
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !io_ack && !cfg_req && !io_pass);
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst) cfg_req |=> !cfg_req);
  a_r8_req_after_io: assert property (@(posedge clk) disable iff (rst) cfg_req |-> $past(io_req));
  a_r3_pass_no_req: assert property (@(posedge clk) disable iff (rst) io_pass |-> io_ack && !cfg_req);
  a_r5_idsel_onehot: assert property (@(posedge clk) disable iff (rst)
    cfg_req && !cfg_type1 |-> $countones(cfg_idsel) == 1 && cfg_addr[1:0] == 2'b00);
  a_r6_type1_form: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_type1 |-> cfg_idsel == 32'd0 && cfg_addr[1:0] == 2'b01);
  a_r7_be_shape: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $countones(cfg_be) == 1 || cfg_be == 4'b0011 || cfg_be == 4'b1100 || cfg_be == 4'b1111);
  a_r9_ack_source: assert property (@(posedge clk) disable iff (rst)
    io_ack && !$past(io_req) |-> $past(cfg_rsp_valid));
endmodule

bind cfg_addr_xlat cfg_addr_xlat_chk u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_ack(io_ack), .io_pass(io_pass),
  .cfg_req(cfg_req), .cfg_type1(cfg_type1), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .cfg_idsel(cfg_idsel), .cfg_rsp_valid(cfg_rsp_valid)
);

// File: tb/test_cfg_addr_xlat.sv
module test_cfg_addr_xlat;
  logic clk = 0, rst = 1;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = 0;
  logic [1:0] io_size = 0;
  logic [31:0] io_wdata = 0;
  logic io_ack, io_pass;
  logic [31:0] io_rdata;
  logic [7:0] primary_bus = 0;
  logic cfg_req, cfg_we, cfg_type1;
  logic [31:0] cfg_addr, cfg_wdata, cfg_idsel;
  logic [3:0] cfg_be;
  logic cfg_rsp_valid = 0, cfg_rsp_err = 0;
  logic [31:0] cfg_rsp_rdata = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_sel = 0;

  logic g_req, g_we, g_t1, g_ack, g_pass;
  logic [31:0] g_addr, g_idsel, g_wd, g_rd;
  logic [3:0] g_be;

  always #2.5 clk = ~clk;

  cfg_addr_xlat i_cfg_addr_xlat (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] f_be(input logic [15:0] a, input logic [1:0] sz);
    if (a[15:2] != 14'h033F) return 4'b0;
    case (sz)
      2'd0: return 4'b0001 << a[1:0];
      2'd1: return a[0] ? 4'b0 : (4'b0011 << a[1:0]);
      2'd2: return (a[1:0] == 2'd0) ? 4'b1111 : 4'b0;
      default: return 4'b0;
    endcase
  endfunction

  function automatic logic [31:0] f_addr(input logic [31:0] s, input logic [7:0] pb);
    if (s[23:16] == pb) return {21'd0, s[10:8], s[7:2], 2'b00};
    return {8'd0, s[23:16], s[15:11], s[10:8], s[7:2], 2'b01};
  endfunction

  function automatic logic [31:0] f_idsel(input logic [31:0] s, input logic [7:0] pb);
    if (s[23:16] != pb) return 32'd0;
    return 32'd1 << s[15:11];
  endfunction

  task automatic xfer(input logic we, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [31:0] rspd, input logic rspe, input int dly);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 0;
    g_req = cfg_req; g_we = cfg_we; g_t1 = cfg_type1; g_addr = cfg_addr;
    g_idsel = cfg_idsel; g_wd = cfg_wdata; g_be = cfg_be;
    if (cfg_req) begin
      repeat (dly) @(negedge clk);
      cfg_rsp_valid = 1; cfg_rsp_rdata = rspd; cfg_rsp_err = rspe;
      @(negedge clk);
      cfg_rsp_valid = 0; cfg_rsp_err = 0;
    end
    g_ack = io_ack; g_pass = io_pass; g_rd = io_rdata;
  endtask

  task automatic sel_write(input logic [31:0] v);
    xfer(1, 16'h0CF8, 2'd2, v, 0, 0, 0);
    if (g_ack) m_sel = v & 32'h80FF_FFFC;
  endtask

  task automatic data_check(input string r, input logic we, input logic [15:0] a, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [31:0] rspd, input logic rspe, input int dly);
    logic [3:0] eb;
    logic claim;
    eb = f_be(a, sz);
    claim = m_sel[31] && eb != 0;
    xfer(we, a, sz, wd, rspd, rspe, dly);
    chk({r, " R8 req"}, 32'(g_req), 32'(claim));
    chk({r, " ack"}, 32'(g_ack), 1);
    chk({r, " R3 pass"}, 32'(g_pass), 32'(!claim));
    if (claim) begin
      chk({r, " R7 be"}, 32'(g_be), 32'(eb));
      chk({r, " R5/R6 addr"}, g_addr, f_addr(m_sel, primary_bus));
      chk({r, " R5 idsel"}, g_idsel, f_idsel(m_sel, primary_bus));
      chk({r, " R6 type"}, 32'(g_t1), 32'(m_sel[23:16] != primary_bus));
      chk({r, " R8 we"}, 32'(g_we), 32'(we));
      if (we) chk({r, " R8 wdata"}, g_wd, wd);
      else chk({r, " R9 rdata"}, g_rd, rspe ? 32'hFFFF_FFFF : rspd);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ack", 32'(io_ack), 0);
    chk("R1 req", 32'(cfg_req), 0);
    chk("R1 pass", 32'(io_pass), 0);
    xfer(0, 16'h0CF8, 2'd2, 0, 0, 0, 0);
    chk("R1 sel reset", g_rd, 0);
    data_check("R4 disabled at reset", 0, 16'h0CFC, 2'd2, 0, 32'h1234, 0, 0);

    sel_write(32'hFFFF_FFFF);
    chk("R2 write ack", 32'(g_ack), 1);
    xfer(0, 16'h0CF8, 2'd2, 0, 0, 0, 0);
    chk("R2 readback mask", g_rd, 32'h80FF_FFFC);

    xfer(1, 16'h0CF8, 2'd0, 32'h0, 0, 0, 0);
    chk("R3 byte to sel port pass", 32'(g_pass), 1);
    xfer(1, 16'h0CFA, 2'd1, 32'h0, 0, 0, 0);
    chk("R3 word to sel port pass", 32'(g_pass), 1);
    xfer(0, 16'h0CF8, 2'd2, 0, 0, 0, 0);
    chk("R3 sel unchanged", g_rd, 32'h80FF_FFFC);
    data_check("R3 other port", 0, 16'h0080, 2'd0, 0, 0, 0, 0);

    sel_write(32'h0012_3456);
    data_check("R4 enable clear", 1, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, 0, 0, 0);

    primary_bus = 8'h03;
    sel_write(32'h8003_F8A4);
    data_check("R5 dev31 local", 0, 16'h0CFC, 2'd2, 0, 32'hCAFE_0001, 0, 1);
    sel_write(32'h8003_0004);
    data_check("R5 dev0 local", 1, 16'h0CFE, 2'd1, 32'h5A5A_0000, 0, 0, 0);
    sel_write(32'h80FF_FFFC);
    data_check("R6 bus ff fwd", 0, 16'h0CFD, 2'd0, 0, 32'h0000_7700, 0, 2);
    data_check("R9 absent target", 0, 16'h0CFC, 2'd2, 0, 32'h1111_2222, 1, 3);
    for (int k = 0; k < 4; k++) data_check("R7 byte lane", 1, 16'h0CFC + 16'(k), 2'd0, 32'h01020304, 0, 0, 0);
    data_check("R7 word odd", 0, 16'h0CFD, 2'd1, 0, 0, 0, 0);
    data_check("R7 dword off", 0, 16'h0CFE, 2'd2, 0, 0, 0, 0);
    data_check("R7 size3", 0, 16'h0CFC, 2'd3, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [31:0] sv;
      if ($urandom_range(0, 3) == 0) begin
        sv = $urandom;
        if ($urandom_range(0, 1) == 1) sv[23:16] = primary_bus;
        sel_write(sv);
        xfer(0, 16'h0CF8, 2'd2, 0, 0, 0, 0);
        chk("R2 random readback", g_rd, m_sel);
      end
      if ($urandom_range(0, 7) == 0) primary_bus = 8'($urandom);
      a = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(16'h0100, 16'h0200))
                                       : 16'h0CFC + 16'($urandom_range(0, 3));
      data_check("R7 R8 R9 random", 1'($urandom), a, 2'($urandom), $urandom, $urandom,
                 ($urandom_range(0, 5) == 0), $urandom_range(0, 3));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule